// File: doc/BRIEF.md
# BCD Decade Up/Down Counter

A single decimal digit counter holding a value from 0 to 9 in BCD. Instead of one count strobe and a direction pin it takes two count strobes: a rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one. Each strobe counts only while the other strobe rests high. Both strobes are asynchronous to the block. Each passes through a synchronizer on the free-running system clock, and its rising edge is found by comparing two successive synchronized samples.

A level-sensitive clear forces the digit to zero and overrides everything else. An active-low load makes the digit follow a 4-bit data input for as long as it is held. Two active-low terminal outputs repeat the low phase of the active strobe when the digit sits at its end value: the carry output at 9 and the borrow output at 0. A higher digit can use these outputs directly as its own strobes. A sticky flag reports strobe edges that were refused because the other strobe was low.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `rst` is high on a clock edge, the digit becomes 0, `seq_err` becomes 0 and both synchronized strobe levels are taken as high.
- R2: An accepted up edge adds one to the digit, and 9 wraps to 0. The digit changes on the third system clock edge that samples the up strobe high after it was low.
- R3: An accepted down edge subtracts one from the digit, and 0 wraps to 9. The timing is the same as in R2.
- R4: While `clr` is high on an edge, the digit becomes 0 on that edge, whatever `load_n`, `din` and the strobes are doing.
- R5: While `load_n` is low and `clr` is low on an edge, the digit takes `din` on that edge.
- R6: `carry_n` is low exactly when the digit is 9 and the synchronized up strobe is low. It goes high in the same cycle that the up rise is detected.
- R7: `borrow_n` is low exactly when the digit is 0 and the synchronized down strobe is low. This also holds while `clr` is asserted.
- R8: An edge on one strobe while the other synchronized strobe is low is refused and sets `seq_err`. Rising edges on both strobes in the same cycle are also refused and set `seq_err`. A refused edge leaves the digit unchanged. `seq_err` stays set until a clear or a load.
- R9: If a strobe is already low when clear or load is released, its next rising edge is counted.
- R10: A loaded code from 10 to 15 is kept as it is. An up step from any value of 9 or more gives 0. A down step from 10 to 15 subtracts one in binary.
- R11: Strobe edges that fall in a clock where clear or load is active have no effect on the digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Value to load |
| up_strb | input | 1 | Up count strobe (asynchronous) |
| dn_strb | input | 1 | Down count strobe (asynchronous) |
| count | output | 4 | Current digit, BCD |
| carry_n | output | 1 | Active-low terminal-count-up output |
| borrow_n | output | 1 | Active-low terminal-count-down output |
| seq_err | output | 1 | Sticky flag for refused strobe edges |

## Verification
The bound assertions check the following on every cycle:
- clear priority and the load path;
- that an active carry or borrow only ever appears at digit 9 or 0;
- that the refusal flag is sticky and that clear or load resets it.

Some behaviour only the bench's scenarios can show:
- counting with wrap-around in both directions;
- the synchronizer latency;
- a strobe held low across the release of clear or load;
- stepping from loaded codes 10 to 15;
- the full clear, load 7, up to 2 and back down to 7 sequence with its terminal pulses.

The behavioural model tracks all of these cycle by cycle.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_MAX = digit_t'(9);
  localparam digit_t DIGIT_MIN = digit_t'(0);

  // up step: anything at or above the top value wraps to zero
  function automatic digit_t step_up(digit_t v);
    return (v >= DIGIT_MAX) ? DIGIT_MIN : v + digit_t'(1);
  endfunction

  // down step: zero wraps to the top value, other codes go down in binary
  function automatic digit_t step_dn(digit_t v);
    return (v == DIGIT_MIN) ? DIGIT_MAX : v - digit_t'(1);
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  output logic lvl,
  output logic rise
);
  localparam int PIPE_W = STAGES + 1;

  // pipe[0..STAGES-1]: synchronizer, pipe[STAGES]: previous synchronized sample
  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[PIPE_W-2:0], strb_in};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/digit_core.sv
module digit_core
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   load_n,
  input  digit_t din,
  input  logic   up_ok,
  input  logic   dn_ok,
  input  logic   refused,
  output digit_t value,
  output logic   err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= DIGIT_MIN;
      err   <= 1'b0;
    end else if (clr) begin
      value <= DIGIT_MIN;
      err   <= 1'b0;
    end else if (!load_n) begin
      value <= din;
      err   <= 1'b0;
    end else begin
      if (up_ok)      value <= step_up(value);
      else if (dn_ok) value <= step_dn(value);
      if (refused)    err   <= 1'b1;
    end
  end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       up_strb,
  input  logic       dn_strb,
  output logic [3:0] count,
  output logic       carry_n,
  output logic       borrow_n,
  output logic       seq_err
);
  localparam int NSTRB = 2;
  localparam int IDX_UP = 0;
  localparam int IDX_DN = 1;

  logic [NSTRB-1:0] strb_raw, strb_lvl, strb_rise;
  assign strb_raw = {dn_strb, up_strb};

  for (genvar g = 0; g < NSTRB; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .strb_in(strb_raw[g]),
      .lvl    (strb_lvl[g]),
      .rise   (strb_rise[g])
    );
  end

  logic up_ok, dn_ok, refused;
  assign up_ok   = strb_rise[IDX_UP] & strb_lvl[IDX_DN] & ~strb_rise[IDX_DN];
  assign dn_ok   = strb_rise[IDX_DN] & strb_lvl[IDX_UP] & ~strb_rise[IDX_UP];
  assign refused = (|strb_rise) & ~up_ok & ~dn_ok;

  digit_t value;
  digit_core u_core (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load_n (load_n),
    .din    (din),
    .up_ok  (up_ok),
    .dn_ok  (dn_ok),
    .refused(refused),
    .value  (value),
    .err    (seq_err)
  );

  assign count    = value;
  // decoded from flops only: the stored digit and the synchronized levels
  assign carry_n  = ~((value == DIGIT_MAX) & ~strb_lvl[IDX_UP]);
  assign borrow_n = ~((value == DIGIT_MIN) & ~strb_lvl[IDX_DN]);
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr,
  input logic       load_n,
  input logic [3:0] din,
  input logic [3:0] count,
  input logic       carry_n,
  input logic       borrow_n,
  input logic       seq_err
);
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == 4'd0));

  assert_load_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(din)));

  assert_carry_at_nine_R6: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count == 4'd9));

  assert_borrow_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count == 4'd0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (seq_err && !clr && load_n) |=> seq_err);

  assert_err_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (clr || !load_n) |=> !seq_err);
endmodule

bind bcd_updown_counter bcd_counter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr     (clr),
  .load_n  (load_n),
  .din     (din),
  .count   (count),
  .carry_n (carry_n),
  .borrow_n(borrow_n),
  .seq_err (seq_err)
);

// File: tb/bcd_updown_counter_bench.sv
module bcd_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       up_strb = 1'b1;
  logic       dn_strb = 1'b1;
  logic [3:0] count;
  logic       carry_n, borrow_n, seq_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bcd_updown_counter u_bcd_updown_counter (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din),
    .up_strb(up_strb), .dn_strb(dn_strb), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n), .seq_err(seq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: strobe history h0 newest, h1 synchronized level, h2 previous
  int  m_cnt = 0;
  int  m_err = 0;
  bit  uh0 = 1, uh1 = 1, uh2 = 1, dh0 = 1, dh1 = 1, dh2 = 1;

  always @(posedge clk) begin
    bit ur, dr;
    if (rst) begin
      m_cnt = 0; m_err = 0;
      uh0 = 1; uh1 = 1; uh2 = 1; dh0 = 1; dh1 = 1; dh2 = 1;
    end else begin
      ur = uh1 && !uh2;
      dr = dh1 && !dh2;
      if (clr) begin m_cnt = 0; m_err = 0; end
      else if (!load_n) begin m_cnt = din; m_err = 0; end
      else if (ur && dh1 && !dr) m_cnt = (m_cnt >= 9) ? 0 : m_cnt + 1;
      else if (dr && uh1 && !ur) m_cnt = (m_cnt == 0) ? 9 : m_cnt - 1;
      else if (ur || dr) m_err = 1;
      uh2 = uh1; uh1 = uh0; uh0 = up_strb;
      dh2 = dh1; dh1 = dh0; dh0 = dn_strb;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2/R3 count vs model", count, m_cnt);
      chk("R6 carry_n vs model", carry_n, !(m_cnt == 9 && !uh1));
      chk("R7 borrow_n vs model", borrow_n, !(m_cnt == 0 && !dh1));
      chk("R8 seq_err vs model", seq_err, m_err);
    end
  end

  task automatic up_pulse();
    @(negedge clk) up_strb = 1'b0;
    repeat (4) @(negedge clk);
    up_strb = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic dn_pulse();
    @(negedge clk) dn_strb = 1'b0;
    repeat (4) @(negedge clk);
    dn_strb = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_load(input int v);
    @(negedge clk) begin din = 4'(v); load_n = 1'b0; end
    repeat (2) @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit saw_carry, saw_borrow;
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset seq_err", seq_err, 0);
    rst = 1'b0;
    @(negedge clk);

    // main sequence: clear, load 7, up to 2, down to 7
    do_clear();
    chk("R4 clear to zero", count, 0);
    do_load(7);
    chk("R5 load 7", count, 7);
    up_pulse(); chk("R2 up 8", count, 8);
    up_pulse(); chk("R2 up 9", count, 9);
    saw_carry = 0;
    @(negedge clk) up_strb = 1'b0;
    repeat (4) @(negedge clk) if (!carry_n) saw_carry = 1;
    chk("R6 carry low at 9", saw_carry, 1);
    up_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 wrap 9 to 0", count, 0);
    chk("R6 carry released", carry_n, 1);
    up_pulse(); chk("R2 up 1", count, 1);
    up_pulse(); chk("R2 up 2", count, 2);
    dn_pulse(); chk("R3 down 1", count, 1);
    dn_pulse(); chk("R3 down 0", count, 0);
    saw_borrow = 0;
    @(negedge clk) dn_strb = 1'b0;
    repeat (4) @(negedge clk) if (!borrow_n) saw_borrow = 1;
    chk("R7 borrow low at 0", saw_borrow, 1);
    dn_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 wrap 0 to 9", count, 9);
    dn_pulse(); chk("R3 down 8", count, 8);
    dn_pulse(); chk("R3 down 7", count, 7);

    // R4 priority over load, R7 borrow during clear
    @(negedge clk) begin clr = 1'b1; load_n = 1'b0; din = 4'd5; dn_strb = 1'b0; end
    repeat (4) @(negedge clk);
    chk("R4 clear beats load", count, 0);
    chk("R7 borrow during clear", borrow_n, 0);
    load_n = 1'b1; clr = 1'b0;
    @(negedge clk);
    // R9: down strobe was low across clear release, its rise counts
    dn_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 held-low strobe counts", count, 9);

    // R11: edges during load ignored
    @(negedge clk) begin din = 4'd3; load_n = 1'b0; up_strb = 1'b0; end
    repeat (3) @(negedge clk);
    up_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 edge during load ignored", count, 3);
    load_n = 1'b1;
    @(negedge clk);

    // R8: up edge while down low is refused
    do_load(5);
    @(negedge clk) dn_strb = 1'b0;
    repeat (4) @(negedge clk);
    up_pulse();
    chk("R8 refused edge no change", count, 5);
    chk("R8 seq_err set", seq_err, 1);
    dn_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 flag sticky, down counts", count, 4);
    chk("R8 flag still set", seq_err, 1);
    // simultaneous rises
    @(negedge clk) begin up_strb = 1'b0; dn_strb = 1'b0; end
    repeat (4) @(negedge clk);
    up_strb = 1'b1; dn_strb = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 simultaneous rises refused", count, 4);
    do_load(2);
    chk("R8 load clears flag", seq_err, 0);

    // R10: invalid codes
    do_load(12); chk("R10 load 12 kept", count, 12);
    up_pulse();  chk("R10 up from 12", count, 0);
    do_load(14); dn_pulse(); chk("R10 down from 14", count, 13);
    do_load(10); dn_pulse(); chk("R10 down from 10", count, 9);

    // R1 again: reset mid-run
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-run", count, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule